// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block takes one incoming Ethernet frame at a time and lays it down in a packet page of the buffer memory. Each frame arrives as a length word on a header handshake, followed by exactly that many payload bytes on a valid/ready byte stream. The block first decides whether the frame may be stored. Receive must be switched on, the hold-in-reset control must be clear, and the stored image must fit in one page. It then asks an external allocator for a page and writes the image one byte per cycle, at rising addresses from zero.

The page image has four parts. It opens with a 16-bit status word and a 16-bit stored-size word, both least-significant byte first. The even part of the payload follows, zero-padded when the frame is short. The frame check sequence comes next, unless it is being discarded. Last is a two-byte trailer that carries an odd final byte and a control code. When the trailer is written, the page number is pushed onto the receive queue and a one-cycle pulse sets the receive interrupt.

A frame that is refused or cannot be placed is still consumed from the byte stream, so the source never stalls. While a frame is in progress the header handshake is closed.

Top module: `rx_frame_writer`

## Requirements
- R1: With `cfg_rx_on` low or `cfg_reset_hold` high when the length is accepted, the frame is refused. All of its bytes are consumed, no memory write occurs and nothing is pushed.
- R2: The stored size S is 64 for a length L below 64, and L with bit 0 cleared otherwise. S then gains 6, plus 4 more when `cfg_drop_fcs` is low. S is written at page addresses 2 (low byte) and 3 (high byte), and the last byte of the image is written at address S-1.
- R3: A frame with S above the page size (2048 bytes by default) is dropped without allocation. Its bytes are consumed. S equal to the page size is stored.
- R4: When the allocator answers with `alloc_ok` low, the frame is dropped and its bytes are consumed, with no write and no push.
- R5: The status word sits at address 0 (low byte) and address 1 (high byte). Bit 11 (0x0800) is set when L exceeds 1518, bit 12 (0x1000) is set when L is odd, and all other bits are zero.
- R6: Payload byte i is written at address 4+i, for every byte except an odd final byte of a frame of 64 bytes or more.
- R7: A frame shorter than 64 bytes keeps its odd last byte in place and is zero-filled up to payload byte 63. Its effective length E is then 64.
- R8: When the check sequence is kept, the standard Ethernet CRC-32 is written in four bytes, least significant first, right after the first (E with bit 0 cleared) payload bytes. It uses reflected polynomial 0xEDB88320, an all-ones start and a final inversion, and covers all E effective bytes, padding included.
- R9: The two trailer bytes close the image. For an odd E they are the final payload byte, then 0x60. For an even E they are 0x00, then 0x40.
- R10: In the cycle after the last trailer write, `rxq_push` and `rcv_irq_set` pulse together for one cycle, with `rxq_page` equal to the page that was written.
- R11: `hdr_ready` is high only when the block is idle, so a new length cannot be taken until the previous frame has been fully written or discarded. `in_ready` is high only while bytes are being stored or drained.
- R12: Within a frame every write goes to the same page, at addresses that start at 0 and rise by one per write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_on | input | 1 | Receive switched on |
| cfg_reset_hold | input | 1 | Receiver held in reset; frames refused |
| cfg_drop_fcs | input | 1 | Discard the check sequence instead of storing it |
| hdr_valid | input | 1 | Frame length offered |
| hdr_ready | output | 1 | Length accepted (block idle) |
| hdr_len | input | LEN_W | Frame length in bytes |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken |
| in_data | input | 8 | Payload byte |
| alloc_req | output | 1 | Page request, held until answered |
| alloc_ack | input | 1 | Allocator answer strobe |
| alloc_ok | input | 1 | Page granted (with `alloc_ack`) |
| alloc_page | input | PAGE_W | Granted page number |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_page | output | PAGE_W | Page being written |
| mem_addr | output | ADDR_W | Byte address within the page |
| mem_wdata | output | 8 | Byte written |
| rxq_push | output | 1 | Push the finished page onto the receive queue |
| rxq_page | output | PAGE_W | Page number pushed |
| rcv_irq_set | output | 1 | Pulse that sets the receive interrupt bit |
| busy | output | 1 | A frame is in progress |

## Verification
On every cycle the assertions check the following:
- addresses within a frame start at zero, rise by one and stay in one page;
- the push carries that page and coincides with the interrupt pulse;
- the push directly follows a 0x40 or 0x60 control write;
- the size written in the header equals the number of bytes written;
- the handshakes stay closed while the block is busy or waiting for the allocator.

Only the bench scenarios can show the byte values themselves. That covers the status flags, the zero fill of short frames, the CRC value and its position ahead of a held odd byte, and the 2048-byte boundary. It also covers the refusal and drop paths, and the fact that a dropped frame still drains every byte without touching memory.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ALLOC,
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_CRC,
        ST_TRL,
        ST_DONE,
        ST_DRAIN
    } rxw_state_e;

    // Per-frame layout decisions, fixed when the length is accepted.
    typedef struct packed {
        logic [15:0] status;    // status word for bytes 0..1
        logic [15:0] stored;    // stored size for bytes 2..3
        logic        short_f;   // length below the minimum frame
        logic        odd_tail;  // effective length is odd
        logic        keep_crc;  // check sequence is written
    } rxw_plan_t;

    localparam int          MIN_FRAME   = 64;
    localparam int          LONG_LIMIT  = 1518;
    localparam int          HDR_EXTRA   = 6;
    localparam int          CRC_EXTRA   = 4;
    localparam logic [15:0] STAT_LONG   = 16'h0800;
    localparam logic [15:0] STAT_ODD    = 16'h1000;
    localparam logic [7:0]  CTL_ODD     = 8'h60;
    localparam logic [7:0]  CTL_EVEN    = 8'h40;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;

    // One byte of the reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxw_sizer.sv
module rxw_sizer
    import rxw_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048
) (
    input  logic [LEN_W-1:0] len,
    input  logic             rx_on,
    input  logic             reset_hold,
    input  logic             drop_fcs,
    output logic             admit,
    output rxw_plan_t        plan
);
    logic [31:0] len_ext;
    logic [31:0] body;
    logic [31:0] total;

    always_comb begin
        len_ext = 32'(len);
        body    = (len_ext < 32'(MIN_FRAME)) ? 32'(MIN_FRAME) : (len_ext & ~32'd1);
        total   = body + 32'(HDR_EXTRA) + (drop_fcs ? 32'd0 : 32'(CRC_EXTRA));

        plan.status   = ((len_ext > 32'(LONG_LIMIT)) ? STAT_LONG : 16'd0)
                      | (len_ext[0] ? STAT_ODD : 16'd0);
        plan.stored   = total[15:0];
        plan.short_f  = len_ext < 32'(MIN_FRAME);
        plan.odd_tail = (len_ext >= 32'(MIN_FRAME)) && len_ext[0];
        plan.keep_crc = !drop_fcs;

        admit = rx_on && !reset_hold && (total <= 32'(PAGE_BYTES));
    end
endmodule

// File: rtl/rxw_crc32.sv
module rxw_crc32
    import rxw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);
    logic [31:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= CRC_SEED;
        end else if (en) begin
            acc_q <= crc32_step(acc_q, din);
        end
    end

    assign crc_out = ~acc_q;
endmodule

// File: rtl/rxw_wdata_mux.sv
module rxw_wdata_mux
    import rxw_pkg::*;
(
    input  rxw_state_e  state,
    input  logic [1:0]  sub,
    input  rxw_plan_t   plan,
    input  logic [7:0]  in_data,
    input  logic [7:0]  odd_byte,
    input  logic [31:0] crc,
    output logic [7:0]  wdata
);
    always_comb begin
        wdata = 8'd0;
        unique case (state)
            ST_HDR: begin
                case (sub)
                    2'd0:    wdata = plan.status[7:0];
                    2'd1:    wdata = plan.status[15:8];
                    2'd2:    wdata = plan.stored[7:0];
                    default: wdata = plan.stored[15:8];
                endcase
            end
            ST_PAY:  wdata = in_data;
            ST_CRC:  wdata = crc[8*sub +: 8];
            ST_TRL: begin
                if (sub == 2'd0) wdata = plan.odd_tail ? odd_byte : 8'd0;
                else             wdata = plan.odd_tail ? CTL_ODD : CTL_EVEN;
            end
            default: wdata = 8'd0;
        endcase
    end
endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer
    import rxw_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int PAGE_W = 2,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rx_on,
    input  logic              cfg_reset_hold,
    input  logic              cfg_drop_fcs,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              alloc_req,
    input  logic              alloc_ack,
    input  logic              alloc_ok,
    input  logic [PAGE_W-1:0] alloc_page,
    output logic              mem_we,
    output logic [PAGE_W-1:0] mem_page,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              rxq_push,
    output logic [PAGE_W-1:0] rxq_page,
    output logic              rcv_irq_set,
    output logic              busy
);
    localparam int               PAGE_BYTES = 1 << ADDR_W;
    localparam logic [LEN_W-1:0] PAD_LAST   = LEN_W'(MIN_FRAME - 1);

    rxw_state_e        state_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        sub_q;
    logic [7:0]        odd_q;
    logic [PAGE_W-1:0] page_q;
    rxw_plan_t         plan_q;

    rxw_plan_t         plan_new;
    logic              admit_new;
    logic [31:0]       crc_fin;
    logic              pay_fire;
    logic              last_byte;
    logic              hold_odd;
    logic              crc_en;
    rxw_state_e        after_data;

    rxw_sizer #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_sizer (
        .len        (hdr_len),
        .rx_on      (cfg_rx_on),
        .reset_hold (cfg_reset_hold),
        .drop_fcs   (cfg_drop_fcs),
        .admit      (admit_new),
        .plan       (plan_new)
    );

    assign pay_fire   = (state_q == ST_PAY) && in_valid;
    assign last_byte  = (cnt_q == len_q - LEN_W'(1));
    assign hold_odd   = last_byte && plan_q.odd_tail;
    assign crc_en     = pay_fire || (state_q == ST_PAD);
    assign after_data = plan_q.keep_crc ? ST_CRC : ST_TRL;

    rxw_crc32 u_crc (
        .clk     (clk),
        .rst     (rst),
        .clr     (state_q == ST_IDLE),
        .en      (crc_en),
        .din     ((state_q == ST_PAY) ? in_data : 8'd0),
        .crc_out (crc_fin)
    );

    rxw_wdata_mux u_mux (
        .state    (state_q),
        .sub      (sub_q),
        .plan     (plan_q),
        .in_data  (in_data),
        .odd_byte (odd_q),
        .crc      (crc_fin),
        .wdata    (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            cnt_q   <= '0;
            addr_q  <= '0;
            sub_q   <= '0;
            odd_q   <= '0;
            page_q  <= '0;
            plan_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (hdr_valid) begin
                        len_q  <= hdr_len;
                        plan_q <= plan_new;
                        cnt_q  <= '0;
                        if (admit_new)            state_q <= ST_ALLOC;
                        else if (hdr_len != '0)   state_q <= ST_DRAIN;
                    end
                end
                ST_ALLOC: begin
                    if (alloc_ack) begin
                        if (alloc_ok) begin
                            page_q  <= alloc_page;
                            addr_q  <= '0;
                            sub_q   <= '0;
                            state_q <= ST_HDR;
                        end else begin
                            state_q <= (len_q == '0) ? ST_IDLE : ST_DRAIN;
                        end
                    end
                end
                ST_HDR: begin
                    addr_q <= addr_q + ADDR_W'(1);
                    sub_q  <= sub_q + 2'd1;
                    if (sub_q == 2'd3) begin
                        state_q <= (len_q == '0) ? ST_PAD : ST_PAY;
                    end
                end
                ST_PAY: begin
                    if (in_valid) begin
                        cnt_q <= cnt_q + LEN_W'(1);
                        if (hold_odd) odd_q  <= in_data;
                        else          addr_q <= addr_q + ADDR_W'(1);
                        if (last_byte) begin
                            state_q <= plan_q.short_f ? ST_PAD : after_data;
                        end
                    end
                end
                ST_PAD: begin
                    addr_q <= addr_q + ADDR_W'(1);
                    cnt_q  <= cnt_q + LEN_W'(1);
                    if (cnt_q == PAD_LAST) state_q <= after_data;
                end
                ST_CRC: begin
                    addr_q <= addr_q + ADDR_W'(1);
                    sub_q  <= sub_q + 2'd1;
                    if (sub_q == 2'd3) state_q <= ST_TRL;
                end
                ST_TRL: begin
                    addr_q <= addr_q + ADDR_W'(1);
                    if (sub_q == 2'd1) begin
                        sub_q   <= 2'd0;
                        state_q <= ST_DONE;
                    end else begin
                        sub_q <= sub_q + 2'd1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                ST_DRAIN: begin
                    if (in_valid) begin
                        cnt_q <= cnt_q + LEN_W'(1);
                        if (last_byte) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign hdr_ready   = (state_q == ST_IDLE);
    assign in_ready    = (state_q == ST_PAY) || (state_q == ST_DRAIN);
    assign alloc_req   = (state_q == ST_ALLOC);
    assign mem_we      = (state_q == ST_HDR) || (state_q == ST_PAD) || (state_q == ST_CRC)
                       || (state_q == ST_TRL) || (pay_fire && !hold_odd);
    assign mem_page    = page_q;
    assign mem_addr    = addr_q;
    assign rxq_push    = (state_q == ST_DONE);
    assign rxq_page    = page_q;
    assign rcv_irq_set = (state_q == ST_DONE);
    assign busy        = (state_q != ST_IDLE);
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int PAGE_W = 2,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              hdr_ready,
    input logic              in_ready,
    input logic              alloc_req,
    input logic              mem_we,
    input logic [PAGE_W-1:0] mem_page,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              rxq_push,
    input logic [PAGE_W-1:0] rxq_page,
    input logic              rcv_irq_set
);
    logic              in_frame;
    logic [ADDR_W-1:0] last_addr;
    logic [PAGE_W-1:0] frame_page;
    logic [15:0]       size_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame   <= 1'b0;
            last_addr  <= '0;
            frame_page <= '0;
            size_seen  <= '0;
        end else if (rxq_push) begin
            in_frame <= 1'b0;
        end else if (mem_we) begin
            in_frame   <= 1'b1;
            last_addr  <= mem_addr;
            frame_page <= mem_page;
            if (mem_addr == ADDR_W'(2)) size_seen[7:0]  <= mem_wdata;
            if (mem_addr == ADDR_W'(3)) size_seen[15:8] <= mem_wdata;
        end
    end

    p_first_addr_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !in_frame) |-> (mem_addr == '0));
    p_seq_addr_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_we && in_frame) |-> (mem_addr == last_addr + ADDR_W'(1)));
    p_same_page_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_we && in_frame) |-> (mem_page == frame_page));
    p_push_page_r10: assert property (@(posedge clk) disable iff (rst)
        rxq_push |-> (in_frame && rxq_page == frame_page));
    p_push_irq_r10: assert property (@(posedge clk) disable iff (rst)
        rxq_push |-> rcv_irq_set);
    p_irq_push_r10: assert property (@(posedge clk) disable iff (rst)
        rcv_irq_set |-> rxq_push);
    p_trailer_r9: assert property (@(posedge clk) disable iff (rst)
        rxq_push |-> ($past(mem_we) && ($past(mem_wdata) == 8'h40 || $past(mem_wdata) == 8'h60)));
    p_size_r2: assert property (@(posedge clk) disable iff (rst)
        rxq_push |-> (size_seen == 16'(last_addr) + 16'd1));
    p_busy_hdr_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !hdr_ready);
    p_inready_r11: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> busy);
    p_alloc_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        alloc_req |-> (!mem_we && !in_ready));
endmodule

bind rx_frame_writer rxw_checker #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_rxw_checker (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .hdr_ready   (hdr_ready),
    .in_ready    (in_ready),
    .alloc_req   (alloc_req),
    .mem_we      (mem_we),
    .mem_page    (mem_page),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .rxq_push    (rxq_push),
    .rxq_page    (rxq_page),
    .rcv_irq_set (rcv_irq_set)
);

// File: tb/tb_rx_frame_writer.sv
module tb_rx_frame_writer;
    localparam int LEN_W  = 12;
    localparam int PAGE_W = 2;
    localparam int ADDR_W = 11;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_rx_on, cfg_reset_hold, cfg_drop_fcs;
    logic              hdr_valid;
    logic              hdr_ready;
    logic [LEN_W-1:0]  hdr_len;
    logic              in_valid;
    logic              in_ready;
    logic [7:0]        in_data;
    logic              alloc_req;
    logic              alloc_ack;
    logic              alloc_ok;
    logic [PAGE_W-1:0] alloc_page;
    logic              mem_we;
    logic [PAGE_W-1:0] mem_page;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              rxq_push;
    logic [PAGE_W-1:0] rxq_page;
    logic              rcv_irq_set;
    logic              busy;

    always #10 clk = ~clk;

    rx_frame_writer #(.LEN_W(LEN_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .cfg_rx_on(cfg_rx_on), .cfg_reset_hold(cfg_reset_hold),
        .cfg_drop_fcs(cfg_drop_fcs), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_len(hdr_len), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .alloc_req(alloc_req), .alloc_ack(alloc_ack), .alloc_ok(alloc_ok),
        .alloc_page(alloc_page), .mem_we(mem_we), .mem_page(mem_page),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rxq_push(rxq_push),
        .rxq_page(rxq_page), .rcv_irq_set(rcv_irq_set), .busy(busy)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    int    q_addr[$];
    int    q_data[$];
    int    q_page[$];
    string q_req[$];
    int    q_push[$];
    logic [7:0] fbuf [0:4095];
    bit    deny_next = 0;
    int    page_next = 0;

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ fbuf[k][b];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic expect_wr(input int a, input int d, input string r);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_page.push_back(page_next);
        q_req.push_back(r);
    endtask

    // Allocator model: answers each request one cycle later.
    initial begin
        alloc_ack  = 0;
        alloc_ok   = 0;
        alloc_page = '0;
        forever begin
            @(posedge clk);
            #1;
            if (alloc_req && !alloc_ack) begin
                alloc_ack  = 1;
                alloc_ok   = !deny_next;
                alloc_page = PAGE_W'(page_next);
            end else begin
                alloc_ack = 0;
            end
        end
    end

    // Monitor: compares every write and push against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_we) begin
                if (q_addr.size() == 0) begin
                    check(0, "R1", int'(mem_addr), -1);
                end else begin
                    int a, d, p;
                    string r;
                    a = q_addr.pop_front();
                    d = q_data.pop_front();
                    p = q_page.pop_front();
                    r = q_req.pop_front();
                    check(int'(mem_addr) == a, "R12", int'(mem_addr), a);
                    check(int'(mem_wdata) == d, r, int'(mem_wdata), d);
                    check(int'(mem_page) == p, "R12", int'(mem_page), p);
                end
            end
            if (!rst && rxq_push) begin
                if (q_push.size() == 0) begin
                    check(0, "R10", int'(rxq_page), -1);
                end else begin
                    int p;
                    p = q_push.pop_front();
                    check(int'(rxq_page) == p, "R10", int'(rxq_page), p);
                    check(rcv_irq_set == 1'b1, "R10", int'(rcv_irq_set), 1);
                    check(q_addr.size() == 0, "R9", q_addr.size(), 0);
                end
            end
        end
    end

    task automatic run_frame(input int len, input int seed, input bit on, input bit hold,
                             input bit dropfcs, input bit deny, input int page, input int gap);
        int  s, e;
        bit  store;
        logic [31:0] c;
        for (int k = 0; k < 4096; k++) fbuf[k] = (k < len) ? 8'((seed + k * 7) ^ (k >> 3)) : 8'd0;
        s = ((len < 64) ? 64 : (len & ~1)) + 6 + (dropfcs ? 0 : 4);
        e = (len < 64) ? 64 : len;
        store = on && !hold && (s <= 2048) && !deny;
        deny_next = deny;
        page_next = page;
        if (store) begin
            int st, a;
            st = ((len > 1518) ? 16'h0800 : 0) | ((len % 2 == 1) ? 16'h1000 : 0);
            expect_wr(0, st & 255, "R5");
            expect_wr(1, st >> 8, "R5");
            expect_wr(2, s & 255, "R2");
            expect_wr(3, s >> 8, "R2");
            a = 4;
            for (int i = 0; i < (e & ~1); i++) begin
                expect_wr(a, int'(fbuf[i]), (i < len) ? "R6" : "R7");
                a++;
            end
            if (!dropfcs) begin
                c = ref_crc(e);
                for (int i = 0; i < 4; i++) begin
                    expect_wr(a, int'(c[8*i +: 8]), "R8");
                    a++;
                end
            end
            if (e % 2 == 1) begin
                expect_wr(a, int'(fbuf[e-1]), "R9");
                expect_wr(a + 1, 8'h60, "R9");
            end else begin
                expect_wr(a, 0, "R9");
                expect_wr(a + 1, 8'h40, "R9");
            end
            check(a + 2 == s, "R2", a + 2, s);
            q_push.push_back(page);
        end
        cfg_rx_on = on;
        cfg_reset_hold = hold;
        cfg_drop_fcs = dropfcs;
        step();
        hdr_valid = 1;
        hdr_len = LEN_W'(len);
        while (!hdr_ready) step();
        step();
        hdr_valid = 0;
        if (store || len > 0) begin
            check(hdr_ready == 1'b0, "R11", int'(hdr_ready), 0);
        end
        for (int k = 0; k < len; k++) begin
            if (gap > 0 && k % 5 == 2) begin
                in_valid = 0;
                repeat (gap) step();
            end
            in_valid = 1;
            in_data = fbuf[k];
            while (!in_ready) step();
            step();
        end
        in_valid = 0;
        while (busy) step();
        repeat (2) step();
        check(q_addr.size() == 0 && q_push.size() == 0,
              store ? "R10" : (deny ? "R4" : ((on && !hold) ? "R3" : "R1")),
              q_addr.size() + q_push.size(), 0);
        check(busy == 1'b0 && hdr_ready == 1'b1, "R11", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL R11 watchdog actual hung expected idle");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        cfg_rx_on = 1;
        cfg_reset_hold = 0;
        cfg_drop_fcs = 0;
        hdr_valid = 0;
        hdr_len = '0;
        in_valid = 0;
        in_data = '0;
        repeat (3) step();
        rst = 0;
        step();
        // Reset state: idle, handshakes in their rest values (R11, R10).
        check(hdr_ready == 1'b1 && busy == 1'b0, "R11", int'(hdr_ready), 1);
        check(in_ready == 1'b0 && alloc_req == 1'b0, "R11", int'(in_ready), 0);
        check(mem_we == 1'b0 && rxq_push == 1'b0 && rcv_irq_set == 1'b0, "R10", int'(rxq_push), 0);

        run_frame(64, 3, 1, 0, 0, 0, 1, 0);      // R2 R6 R8 R9 exact minimum
        run_frame(10, 9, 1, 0, 0, 0, 0, 2);      // R7 short even, CRC over padding
        run_frame(11, 17, 1, 0, 1, 0, 2, 3);     // R5 odd flag, R7 short odd, FCS dropped
        run_frame(101, 5, 1, 0, 0, 0, 0, 1);     // R8 R9 CRC ahead of held odd byte
        run_frame(65, 40, 1, 0, 1, 0, 1, 2);     // R9 odd trailer, no CRC
        run_frame(0, 0, 1, 0, 0, 0, 0, 3);       // R7 empty frame fully padded
        run_frame(1520, 77, 1, 0, 1, 0, 0, 0);   // R5 long flag
        run_frame(20, 1, 0, 0, 0, 0, 1, 1);      // R1 receive off
        run_frame(20, 2, 1, 1, 0, 0, 0, 1);      // R1 held in reset
        run_frame(2040, 4, 1, 0, 0, 0, 0, 2);    // R3 stored size 2050 dropped
        run_frame(2039, 6, 1, 0, 0, 0, 0, 2);    // R3 stored size 2048 kept
        run_frame(30, 8, 1, 0, 0, 1, 1, 1);      // R4 allocator refuses
        run_frame(70, 12, 1, 0, 0, 0, 3, 3);     // R6 stalled stream after a drop

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule